// File: doc/BRIEF.md
# Shader Flow-Control Stack Sequencer

This block owns the program counter of a small shader processor and a bounded stack of control frames. Subroutine calls, two-way if/else regions and counted loops all use one frame layout: a closing address, a resume address, a remaining-pass count, a per-pass step for the loop counter, and the address where a loop body begins. In every cycle the sequencer first compares the program counter with the closing address of the frame on top. On a match it spends that cycle closing or repeating the frame, and nothing is fetched. When there is no match it presents the program counter for fetch and acts on the decoded flow-control class of the instruction that arrives.

A neighbouring decoder extracts the fields from the instruction word. The target address comes from bits 21:10 and the length from bits 7:0. The same decoder uses bits 25:22 to pick a boolean uniform and bits 23:22 to pick an integer uniform. It then presents the chosen uniform values, together with the condition-code result, on the inputs of this block. A start pulse loads an entry address and begins execution. An end instruction stops execution until the next start pulse.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, pc is 0, loopCnt is 0, running is 0, overflow is 0 and fetchEn is 0.
- R2: A start pulse loads pc from startPc, clears loopCnt and overflow, empties the stack and sets running. A class-0 (step) instruction advances pc by 1.
- R3: Call classes are 2 (always), 3 (taken when condOk is 1) and 4 (taken when boolUni is 1). A taken call sets pc to flowTgt and pushes a frame with closing address flowTgt+flowLen, resume address call-address+1, pass count 0 and step 0. A call that is not taken advances pc by 1.
- R4: When the stack is non-empty and pc equals the top frame's closing address, fetchEn is 0 for that cycle and loopCnt gains the frame's step. If the pass count is 0, the frame pops and pc takes the resume address. Otherwise the pass count drops by 1 and pc takes the loop-start address.
- R5: The closing-address check runs again in the cycle after every pop or repeat. Nested frames that close at the same address therefore unwind one per cycle, with no fetch in between.
- R6: If classes are 5 (tested on condOk) and 6 (tested on boolUni). On true, pc advances by 1 and the pushed frame closes at flowTgt. On false, pc jumps to flowTgt and the frame closes at flowTgt+flowLen. Both cases resume at flowTgt+flowLen.
- R7: Loop class 7 reads intUni with the pass count in bits 7:0, the initial counter in bits 15:8 and the step in bits 23:16. It loads loopCnt from the initial counter. The body, from loop-address+1 through flowTgt inclusive, runs pass-count+1 times. After the last pass, pc becomes flowTgt+1.
- R8: Jump classes are 8 (taken when condOk is 1) and 9 (taken when boolUni is 1). A taken jump sets pc to flowTgt and leaves the stack unchanged. A jump that is not taken advances pc by 1.
- R9: End class 1 clears running and holds pc. From then until the next start, fetchEn stays 0 and pc and loopCnt do not change.
- R10: A push with DEPTH frames already stacked sets overflow. The push is dropped, pc advances by 1 and loopCnt is unchanged. overflow then stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load startPc and begin execution |
| startPc | input | 12 | Entry address |
| opClass | input | 4 | Flow-control class of the fetched instruction |
| flowTgt | input | 12 | Decoded target address field |
| flowLen | input | 8 | Decoded length field |
| condOk | input | 1 | Result of the condition-code test |
| boolUni | input | 1 | Selected boolean uniform |
| intUni | input | 24 | Selected integer uniform (pass count, initial counter, step) |
| pc | output | 12 | Program counter |
| fetchEn | output | 1 | The instruction at pc is consumed this cycle |
| loopCnt | output | 8 | Loop counter register |
| running | output | 1 | Execution active |
| overflow | output | 1 | Sticky flag: a push was dropped |

## Verification
The checks assume three things about the inputs. The decoded fields, the class, condOk and the uniforms are stable during the cycle they are used and belong to the instruction at pc. The class is one of the ten defined values. start is a single-cycle pulse. The stimulus meets these assumptions by driving all inputs on the falling edge from a program table indexed by the current pc, and by drawing random classes only from 0 to 9. Random programs wander freely, overflow the stack and run into loops. Every cycle is compared against a bench model of the frame rules.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 8;
  localparam int LEN_W  = 8;
  localparam int UNI_W  = 3 * CNT_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    addr_t endA;
    addr_t retA;
    cnt_t  rep;
    cnt_t  inc;
    addr_t loopA;
  } frame_t;

  typedef enum logic [3:0] {
    OP_STEP  = 4'd0,
    OP_END   = 4'd1,
    OP_CALL  = 4'd2,
    OP_CALLC = 4'd3,
    OP_CALLU = 4'd4,
    OP_IFC   = 4'd5,
    OP_IFU   = 4'd6,
    OP_LOOP  = 4'd7,
    OP_JMPC  = 4'd8,
    OP_JMPU  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    PC_HOLD, PC_INC, PC_TGT, PC_RET, PC_LOOP, PC_LOAD
  } pcsel_e;

  typedef enum logic [1:0] {
    FK_CALL, FK_IFT, FK_IFF, FK_LOOP
  } fkind_e;

  typedef struct packed {
    pcsel_e pcSel;
    fkind_e kind;
    logic   push;
    logic   pop;
    logic   decRep;
    logic   addInc;
    logic   loadCnt;
    logic   clrCnt;
    logic   clrStack;
    logic   setOvf;
    logic   clrOvf;
  } strobe_t;
endpackage

// File: rtl/fcs_frame_stack.sv
module fcs_frame_stack
  import fcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   clr,
  input  logic   push,
  input  logic   pop,
  input  logic   decRep,
  input  frame_t pushFrame,
  output frame_t topFrame,
  output logic   topValid,
  output logic   full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  frame_t        slots [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slots[i] <= '0;
        end else if (push && !full && count == CW'(i)) begin
          slots[i] <= pushFrame;
        end else if (decRep && count == CW'(i + 1)) begin
          slots[i].rep <= slots[i].rep - 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + 1'b1;
    end else if (pop && topValid) begin
      count <= count - 1'b1;
    end
  end

  always_comb begin
    topFrame = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count == CW'(i + 1)) topFrame = slots[i];
    end
  end

  assign topValid = (count != '0);
  assign full     = (count == CW'(DEPTH));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] opClass,
  input  logic       condOk,
  input  logic       boolUni,
  input  logic       atEnd,
  input  logic       topRepZero,
  input  logic       stackFull,
  output strobe_t    st,
  output logic       running,
  output logic       fetchEn
);
  op_e  op;
  logic take;
  logic haltNow;

  assign op = op_e'(opClass);

  always_comb begin
    st       = '0;
    st.pcSel = PC_HOLD;
    st.kind  = FK_CALL;
    fetchEn  = 1'b0;
    take     = 1'b0;
    haltNow  = 1'b0;
    if (start) begin
      st.pcSel    = PC_LOAD;
      st.clrCnt   = 1'b1;
      st.clrStack = 1'b1;
      st.clrOvf   = 1'b1;
    end else if (running) begin
      if (atEnd) begin
        st.addInc = 1'b1;
        if (topRepZero) begin
          st.pop   = 1'b1;
          st.pcSel = PC_RET;
        end else begin
          st.decRep = 1'b1;
          st.pcSel  = PC_LOOP;
        end
      end else begin
        fetchEn = 1'b1;
        case (op)
          OP_END: haltNow = 1'b1;
          OP_CALL, OP_CALLC, OP_CALLU: begin
            take = (op == OP_CALL) || (op == OP_CALLC && condOk) ||
                   (op == OP_CALLU && boolUni);
            if (!take) begin
              st.pcSel = PC_INC;
            end else if (stackFull) begin
              st.setOvf = 1'b1;
              st.pcSel  = PC_INC;
            end else begin
              st.push  = 1'b1;
              st.kind  = FK_CALL;
              st.pcSel = PC_TGT;
            end
          end
          OP_IFC, OP_IFU: begin
            take = (op == OP_IFC) ? condOk : boolUni;
            if (stackFull) begin
              st.setOvf = 1'b1;
              st.pcSel  = PC_INC;
            end else begin
              st.push  = 1'b1;
              st.kind  = take ? FK_IFT : FK_IFF;
              st.pcSel = take ? PC_INC : PC_TGT;
            end
          end
          OP_LOOP: begin
            st.pcSel = PC_INC;
            if (stackFull) begin
              st.setOvf = 1'b1;
            end else begin
              st.push    = 1'b1;
              st.kind    = FK_LOOP;
              st.loadCnt = 1'b1;
            end
          end
          OP_JMPC, OP_JMPU: begin
            take     = (op == OP_JMPC) ? condOk : boolUni;
            st.pcSel = take ? PC_TGT : PC_INC;
          end
          default: st.pcSel = PC_INC;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
    end else if (haltNow) begin
      running <= 1'b0;
    end
  end
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [ADDR_W-1:0] flowTgt,
  input  logic [LEN_W-1:0]  flowLen,
  input  logic [UNI_W-1:0]  intUni,
  output logic [ADDR_W-1:0] pc,
  output logic [CNT_W-1:0]  loopCnt,
  output logic             overflow,
  output logic             atEnd,
  output logic             topRepZero,
  output logic             stackFull,
  output frame_t           topFrame
);
  addr_t  pcInc;
  addr_t  tgtEnd;
  addr_t  tgtInc;
  cnt_t   passCnt;
  cnt_t   initCnt;
  cnt_t   stepCnt;
  frame_t pushFrame;
  logic   topValid;

  assign pcInc   = pc + 1'b1;
  assign tgtEnd  = flowTgt + ADDR_W'(flowLen);
  assign tgtInc  = flowTgt + 1'b1;
  assign passCnt = intUni[CNT_W-1:0];
  assign initCnt = intUni[2*CNT_W-1:CNT_W];
  assign stepCnt = intUni[3*CNT_W-1:2*CNT_W];

  always_comb begin
    pushFrame = '0;
    case (st.kind)
      FK_CALL: begin
        pushFrame.endA  = tgtEnd;
        pushFrame.retA  = pcInc;
        pushFrame.loopA = flowTgt;
      end
      FK_IFT: begin
        pushFrame.endA  = flowTgt;
        pushFrame.retA  = tgtEnd;
        pushFrame.loopA = pcInc;
      end
      FK_IFF: begin
        pushFrame.endA  = tgtEnd;
        pushFrame.retA  = tgtEnd;
        pushFrame.loopA = flowTgt;
      end
      default: begin
        pushFrame.endA  = tgtInc;
        pushFrame.retA  = tgtInc;
        pushFrame.rep   = passCnt;
        pushFrame.inc   = stepCnt;
        pushFrame.loopA = pcInc;
      end
    endcase
  end

  fcs_frame_stack #(.DEPTH(DEPTH)) stack_i (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (st.clrStack),
    .push     (st.push),
    .pop      (st.pop),
    .decRep   (st.decRep),
    .pushFrame(pushFrame),
    .topFrame (topFrame),
    .topValid (topValid),
    .full     (stackFull)
  );

  assign atEnd      = topValid && (pc == topFrame.endA);
  assign topRepZero = (topFrame.rep == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
    end else begin
      case (st.pcSel)
        PC_INC:  pc <= pcInc;
        PC_TGT:  pc <= flowTgt;
        PC_RET:  pc <= topFrame.retA;
        PC_LOOP: pc <= topFrame.loopA;
        PC_LOAD: pc <= startPc;
        default: pc <= pc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopCnt <= '0;
    end else if (st.clrCnt) begin
      loopCnt <= '0;
    end else if (st.loadCnt) begin
      loopCnt <= initCnt;
    end else if (st.addInc) begin
      loopCnt <= loopCnt + topFrame.inc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (st.clrOvf) begin
      overflow <= 1'b0;
    end else if (st.setOvf) begin
      overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
  import fcs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [11:0] startPc,
  input  logic [3:0]  opClass,
  input  logic [11:0] flowTgt,
  input  logic [7:0]  flowLen,
  input  logic        condOk,
  input  logic        boolUni,
  input  logic [23:0] intUni,
  output logic [11:0] pc,
  output logic        fetchEn,
  output logic [7:0]  loopCnt,
  output logic        running,
  output logic        overflow
);
  strobe_t st;
  logic    atEnd;
  logic    topRepZero;
  logic    stackFull;
  frame_t  topFrame;

  fcs_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opClass   (opClass),
    .condOk    (condOk),
    .boolUni   (boolUni),
    .atEnd     (atEnd),
    .topRepZero(topRepZero),
    .stackFull (stackFull),
    .st        (st),
    .running   (running),
    .fetchEn   (fetchEn)
  );

  fcs_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .startPc   (startPc),
    .flowTgt   (flowTgt),
    .flowLen   (flowLen),
    .intUni    (intUni),
    .pc        (pc),
    .loopCnt   (loopCnt),
    .overflow  (overflow),
    .atEnd     (atEnd),
    .topRepZero(topRepZero),
    .stackFull (stackFull),
    .topFrame  (topFrame)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [3:0]  opClass,
  input logic [11:0] flowTgt,
  input logic        condOk,
  input logic [11:0] pc,
  input logic        fetchEn,
  input logic [7:0]  loopCnt,
  input logic        running,
  input logic        overflow,
  input logic        atEnd,
  input frame_t      topFrame
);
  // R4, R5: a closing cycle never fetches
  a_r4_no_fetch_on_close: assert property (@(posedge clk) disable iff (!rstN)
    atEnd |-> !fetchEn);

  a_r4_pop_resume: assert property (@(posedge clk) disable iff (!rstN)
    (running && !start && atEnd && topFrame.rep == '0) |=> pc == $past(topFrame.retA));

  a_r4_repeat_body: assert property (@(posedge clk) disable iff (!rstN)
    (running && !start && atEnd && topFrame.rep != '0) |=> pc == $past(topFrame.loopA));

  a_r7_step_added: assert property (@(posedge clk) disable iff (!rstN)
    (running && !start && atEnd) |=> loopCnt == 8'($past(loopCnt) + $past(topFrame.inc)));

  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && !start && opClass == 4'd0) |=> pc == 12'($past(pc) + 12'd1));

  a_r8_jump_taken: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && !start && opClass == 4'd8 && condOk) |=> pc == $past(flowTgt));

  a_r9_halt: assert property (@(posedge clk) disable iff (!rstN)
    (fetchEn && !start && opClass == 4'd1) |=> !running);

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !start) |=> overflow);
endmodule

bind shader_flow_seq fcs_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opClass (opClass),
  .flowTgt (flowTgt),
  .condOk  (condOk),
  .pc      (pc),
  .fetchEn (fetchEn),
  .loopCnt (loopCnt),
  .running (running),
  .overflow(overflow),
  .atEnd   (atEnd),
  .topFrame(topFrame)
);

// File: tb/shader_flow_seq_tb_top.sv
module shader_flow_seq_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] startPc = '0;
  logic [3:0]  opClass = '0;
  logic [11:0] flowTgt = '0;
  logic [7:0]  flowLen = '0;
  logic        condOk = 1'b0;
  logic        boolUni = 1'b0;
  logic [23:0] intUni = '0;
  logic [11:0] pc;
  logic        fetchEn;
  logic [7:0]  loopCnt;
  logic        running;
  logic        overflow;

  always #10 clk = ~clk;

  shader_flow_seq #(.DEPTH(DEPTH)) dut_i (.*);

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // program table, indexed by pc[4:0]
  logic [3:0]  pOp   [32];
  logic [11:0] pTgt  [32];
  logic [7:0]  pLen  [32];
  logic        pCond [32];
  logic        pBool [32];
  logic [23:0] pInt  [32];

  // bench model of the frame rules
  logic [11:0] mPc = '0;
  logic [7:0]  mCnt = '0;
  logic        mRun = 0;
  logic        mOvf = 0;
  int          mSp = 0;
  logic [11:0] fEnd [8];
  logic [11:0] fRet [8];
  logic [11:0] fLoop[8];
  logic [7:0]  fRep [8];
  logic [7:0]  fInc [8];

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mAtEnd();
    if (mSp == 0) return 0;
    return mPc == fEnd[mSp-1];
  endfunction

  task mPush(input logic [11:0] e, input logic [11:0] r, input logic [7:0] rp,
             input logic [7:0] in, input logic [11:0] lp);
    fEnd[mSp] = e; fRet[mSp] = r; fRep[mSp] = rp; fInc[mSp] = in; fLoop[mSp] = lp;
    mSp++;
  endtask

  task modelStep();
    logic [11:0] t, te;
    bit take;
    t  = flowTgt;
    te = flowTgt + {4'b0, flowLen};
    if (start) begin
      mPc = startPc; mCnt = 0; mSp = 0; mOvf = 0; mRun = 1;
    end else if (mRun) begin
      if (mAtEnd()) begin
        mCnt = mCnt + fInc[mSp-1];
        if (fRep[mSp-1] == 0) begin
          mPc = fRet[mSp-1];
          mSp--;
        end else begin
          fRep[mSp-1] = fRep[mSp-1] - 1;
          mPc = fLoop[mSp-1];
        end
      end else begin
        case (opClass)
          4'd1: mRun = 0;
          4'd2, 4'd3, 4'd4: begin
            take = (opClass == 2) || (opClass == 3 && condOk) || (opClass == 4 && boolUni);
            if (!take) mPc = mPc + 1;
            else if (mSp == DEPTH) begin mOvf = 1; mPc = mPc + 1; end
            else begin mPush(te, mPc + 12'd1, 0, 0, t); mPc = t; end
          end
          4'd5, 4'd6: begin
            take = (opClass == 5) ? condOk : boolUni;
            if (mSp == DEPTH) begin mOvf = 1; mPc = mPc + 1; end
            else if (take) begin mPush(t, te, 0, 0, mPc + 12'd1); mPc = mPc + 1; end
            else begin mPush(te, te, 0, 0, t); mPc = t; end
          end
          4'd7: begin
            if (mSp == DEPTH) mOvf = 1;
            else begin
              mCnt = intUni[15:8];
              mPush(t + 12'd1, t + 12'd1, intUni[7:0], intUni[23:16], mPc + 12'd1);
            end
            mPc = mPc + 1;
          end
          4'd8, 4'd9: begin
            take = (opClass == 8) ? condOk : boolUni;
            mPc = take ? t : mPc + 12'd1;
          end
          default: mPc = mPc + 1;
        endcase
      end
    end
  endtask

  // called just after a falling edge
  task automatic stepOne(input string tag, input bit doStart, input logic [11:0] sp);
    int a;
    logic expFetch;
    a = int'(mPc[4:0]);
    start = doStart; startPc = sp;
    opClass = pOp[a]; flowTgt = pTgt[a]; flowLen = pLen[a];
    condOk = pCond[a]; boolUni = pBool[a]; intUni = pInt[a];
    #1;
    expFetch = mRun && !doStart && !mAtEnd();
    chk({tag, " fetchEn"}, {31'd0, fetchEn}, {31'd0, expFetch});
    @(posedge clk);
    modelStep();
    @(negedge clk);
    start = 0;
    chk({tag, " state"}, {9'd0, running, overflow, loopCnt, pc}, {9'd0, mRun, mOvf, mCnt, mPc});
  endtask

  task automatic clearProg();
    for (int i = 0; i < 32; i++) begin
      pOp[i] = 4'd1; pTgt[i] = 0; pLen[i] = 0; pCond[i] = 0; pBool[i] = 0; pInt[i] = 0;
    end
  endtask

  task automatic setI(input int a, input logic [3:0] op, input int t, input int l,
                      input bit c, input bit b, input logic [23:0] u);
    pOp[a] = op; pTgt[a] = 12'(t); pLen[a] = 8'(l); pCond[a] = c; pBool[a] = b; pInt[a] = u;
  endtask

  task automatic runProg(input string tag, input logic [11:0] sp, input int maxc);
    stepOne(tag, 1, sp);
    chk("R2 start loads pc", {20'd0, pc}, {20'd0, sp});
    chk("R2 start clears counter/flag", {23'd0, running, overflow, loopCnt}, {23'd0, 1'b1, 1'b0, 8'd0});
    for (int k = 0; k < maxc && mRun; k++) stepOne(tag, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    clearProg();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset state", {17'd0, fetchEn, running, overflow, loopCnt, pc}, 32'd0);
    stepOne("R9 idle before start", 0, 0);

    // R3 call and return
    clearProg();
    setI(0, 4'd2, 8, 2, 0, 0, 0);
    setI(8, 4'd0, 0, 0, 0, 0, 0);
    setI(9, 4'd0, 0, 0, 0, 0, 0);
    runProg("R3 call", 12'd0, 20);
    chk("R3 call returns to call+1", {20'd0, pc}, 32'd1);
    chk("R9 halted", {31'd0, running}, 32'd0);
    stepOne("R9 idle after end", 0, 0);
    chk("R9 pc holds", {20'd0, pc}, 32'd1);

    // R7 counted loop: x=2 y=5 z=3 -> 5+3*3
    clearProg();
    setI(0, 4'd7, 2, 0, 0, 0, {8'd3, 8'd5, 8'd2});
    setI(1, 4'd0, 0, 0, 0, 0, 0);
    setI(2, 4'd0, 0, 0, 0, 0, 0);
    runProg("R7 loop", 12'd0, 40);
    chk("R7 loop counter", {24'd0, loopCnt}, 32'd14);
    chk("R7 exit at target+1", {20'd0, pc}, 32'd3);

    // R6 if true and false
    clearProg();
    setI(0, 4'd5, 3, 2, 1, 0, 0);
    for (int i = 1; i < 5; i++) setI(i, 4'd0, 0, 0, 0, 0, 0);
    runProg("R6 if true", 12'd0, 20);
    chk("R6 if true ends at resume", {20'd0, pc}, 32'd5);
    setI(0, 4'd6, 3, 2, 0, 0, 0);
    runProg("R6 if false", 12'd0, 20);
    chk("R6 if false ends at resume", {20'd0, pc}, 32'd5);

    // R5 nested frames closing at the same address
    clearProg();
    setI(0, 4'd2, 4, 3, 0, 0, 0);
    setI(4, 4'd7, 6, 0, 0, 0, {8'd2, 8'd0, 8'd1});
    setI(5, 4'd0, 0, 0, 0, 0, 0);
    setI(6, 4'd0, 0, 0, 0, 0, 0);
    runProg("R5 nested unwind", 12'd0, 40);
    chk("R5 unwound to outer resume", {20'd0, pc}, 32'd1);
    chk("R5 loop counter", {24'd0, loopCnt}, 32'd4);

    // R10 overflow
    clearProg();
    for (int i = 0; i < 5; i++) setI(i, 4'd2, i + 1, 50, 0, 0, 0);
    runProg("R10 overflow", 12'd0, 20);
    chk("R10 overflow set", {31'd0, overflow}, 32'd1);
    chk("R10 dropped push advances", {20'd0, pc}, 32'd5);
    runProg("R10 restart", 12'd5, 5);
    chk("R10 start clears overflow", {31'd0, overflow}, 32'd0);

    // R8 jumps
    clearProg();
    setI(0, 4'd8, 5, 0, 1, 0, 0);
    setI(5, 4'd9, 9, 0, 0, 0, 0);
    setI(6, 4'd8, 20, 0, 0, 0, 0);
    setI(7, 4'd9, 10, 0, 0, 1, 0);
    runProg("R8 jumps", 12'd0, 20);
    chk("R8 jump chain", {20'd0, pc}, 32'd10);

    // R4 and all classes: random programs against the model
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < 32; i++) begin
        logic [3:0] op;
        int r;
        r = int'($urandom_range(0, 19));
        op = (r < 9) ? 4'd0 : (r == 19 ? 4'd1 : 4'(r - 9));
        if (op == 4'd1 && $urandom_range(0, 1) == 0) op = 4'd0;
        setI(i, op, int'($urandom_range(0, 31)), int'($urandom_range(0, 4)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             {8'($urandom), 8'($urandom), 8'($urandom_range(0, 2))});
      end
      runProg("R4 random", 12'($urandom_range(0, 31)), 200);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule